// File: doc/BRIEF.md
# Floating-Point Exception Detect and Masked Response Stage

This stage sits after a floating-point datapath and its rounder. For each completed operation it receives the class of each operand, the operation code, the sign of the result, the rounding mode, the rounder's overflow, underflow and inexact indications, a register-stack error indication, the six-bit exception mask and the destination format. From these it works out which of the six exceptions the operation raised: invalid, denormal operand, zero divide, overflow, underflow and precision. It then chooses how the result is delivered: the rounded result unchanged, a default replacement, or no delivery at all so that a trap can be taken.

The flags are sticky and are cleared only by an explicit clear input. A stack-fault bit records that an invalid came from register-stack overflow or underflow. A summary error output is high whenever a flag is set whose exception is unmasked. The results come out one cycle after the operation is presented. The arithmetic itself happens elsewhere. This block only classifies the outcome and picks the replacement.

Top module: `fp_exc_resolve`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid`. When `out_valid` is low, `repl_sel` is 0.
- R2: Invalid (flag bit 0) is raised by any of the following:
  - a signalling-NaN operand (class 5);
  - an unsupported operand (class 6 or 7);
  - zero times infinity (op 2);
  - 0/0 or infinity/infinity (op 3);
  - infinity plus infinity of opposite signs (op 0), or infinity minus infinity of equal signs (op 1);
  - `stk_err`, which also sets `stack_fault`.

  The class codes are 0 normal, 1 zero, 2 denormal, 3 infinity and 4 quiet NaN.
- R3: When invalid is raised, `repl_sel` depends on mask bit 0 and `dest_fmt`:
  - with the mask bit at 1 (masked), `dest_fmt` 0 or 3 (real) gives 1 (quiet NaN), 1 (integer) gives 2 (integer indefinite), and 2 (BCD) gives 3 (BCD indefinite);
  - with the mask bit at 0, `repl_sel` is 7 (no delivery).
- R4: Zero divide (bit 2) is raised only by op 3 with a zero divisor B and a normal or denormal dividend A.
  - 0/0 raises invalid instead, and infinity/0 raises nothing.
  - When the exception is masked, `repl_sel` is 4 (signed infinity). When it is unmasked, `repl_sel` is 7.
- R5: Denormal (bit 1) is raised when a used operand has class 2 and the operation raised no invalid.
  - Masked: processing continues normally.
  - Unmasked: `repl_sel` is 7, and the rounder's indications are ignored.
- R6: Overflow (bit 3), when masked, gives `repl_sel` 4 (infinity) or 5 (largest finite), chosen by `rnd_mode` and `res_sign`:
  - nearest (0) gives infinity;
  - toward zero (3) gives largest finite;
  - down (1) gives infinity only for a negative result;
  - up (2) gives infinity only for a positive result.

  When unmasked, `repl_sel` is 7.
- R7: Underflow (bit 4) is handled as follows:
  - When masked, it is raised only when `rnd_unf` and `rnd_inx` are both high, and then `repl_sel` is 6 (denormal or zero).
  - When unmasked, it is raised on `rnd_unf` alone, and `repl_sel` is 7.
- R8: Precision (bit 5) is raised on `rnd_inx`. When no other exception applies, `repl_sel` is 0 (rounded result unchanged) whether precision is masked or not.
- R9: An operation that raises invalid or zero divide, or that has a quiet-NaN operand, raises no overflow, underflow or precision, whatever the rounder reports.
- R10: Flags and `stack_fault` are sticky. `clr_flags` clears them on the next edge. The events of an operation presented in the same cycle as `clr_flags` are kept.
- R11: `err_summary` is the OR of the set flags whose mask bit is 0. Mask bit order is invalid, denormal, zero divide, overflow, underflow, precision (bit 0 to bit 5), and 1 means masked.
- R12: Ops 4 to 7 use a single operand, and B is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation outcome presented this cycle |
| op | input | 3 | 0 add, 1 sub, 2 mul, 3 div, 4-7 single operand |
| a_cls | input | 3 | Class of operand A (dividend) |
| b_cls | input | 3 | Class of operand B (divisor) |
| a_sign | input | 1 | Sign of operand A |
| b_sign | input | 1 | Sign of operand B |
| res_sign | input | 1 | Sign of the result |
| rnd_mode | input | 2 | 0 nearest, 1 down, 2 up, 3 toward zero |
| rnd_ovf | input | 1 | Rounder overflow |
| rnd_unf | input | 1 | Rounder tiny nonzero result |
| rnd_inx | input | 1 | Rounder inexact |
| stk_err | input | 1 | Register-stack overflow or underflow |
| mask_bits | input | 6 | Exception masks, 1 = masked |
| dest_fmt | input | 2 | 0 real, 1 integer, 2 BCD, 3 real |
| clr_flags | input | 1 | Clear sticky flags |
| flags | output | 6 | Sticky exception flags |
| stack_fault | output | 1 | Sticky stack-fault bit |
| err_summary | output | 1 | Any unmasked flag set |
| repl_sel | output | 3 | Result replacement select |
| out_valid | output | 1 | Result valid strobe |

## Verification
The hardest cases to reach are those where several causes meet in one operation. Examples are a denormal dividend over a zero divisor, an unmasked denormal while the rounder also reports overflow, and an invalid form while the rounder flags are all high. Here precedence and suppression decide the outcome. The stimulus drives these collisions on purpose, with every rounder indication raised at once. It also sweeps all four rounding modes against both result signs for masked overflow. Separate clears between groups of operations, and a clear that coincides with a new operation, confirm that stickiness does not hide a missing flag.

// File: rtl/fp_exc_resolve.sv
module fp_exc_resolve #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [2:0]       a_cls,
  input  logic [2:0]       b_cls,
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic             res_sign,
  input  logic [1:0]       rnd_mode,
  input  logic             rnd_ovf,
  input  logic             rnd_unf,
  input  logic             rnd_inx,
  input  logic             stk_err,
  input  logic [NFLAG-1:0] mask_bits,
  input  logic [1:0]       dest_fmt,
  input  logic             clr_flags,
  output logic [NFLAG-1:0] flags,
  output logic             stack_fault,
  output logic             err_summary,
  output logic [2:0]       repl_sel,
  output logic             out_valid
);
  localparam logic [2:0] C_NORM = 3'd0, C_ZERO = 3'd1, C_DEN = 3'd2, C_INF = 3'd3,
                         C_QNAN = 3'd4, C_SNAN = 3'd5;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_DIV = 3'd3;
  localparam logic [2:0] S_PASS = 3'd0, S_QNAN = 3'd1, S_IIND = 3'd2, S_BIND = 3'd3,
                         S_INF = 3'd4, S_MAXF = 3'd5, S_DENZ = 3'd6, S_HOLD = 3'd7;
  localparam int B_INV = 0, B_DEN = 1, B_ZD = 2, B_OVF = 3, B_UNF = 4, B_PRC = 5;

  logic [2:0] b_use;
  logic a_zero, b_zero, a_inf, b_inf, a_fin_nz;
  logic bad_cls, qnan_any, eff_sub, indet;
  logic ev_inv, ev_zd, ev_den, arith_ok, ovf_to_inf;
  logic [NFLAG-1:0] ev;
  logic [2:0] sel_d;

  assign b_use    = op[2] ? C_NORM : b_cls;
  assign a_zero   = a_cls == C_ZERO;
  assign b_zero   = b_use == C_ZERO;
  assign a_inf    = a_cls == C_INF;
  assign b_inf    = b_use == C_INF;
  assign a_fin_nz = (a_cls == C_NORM) || (a_cls == C_DEN);
  assign bad_cls  = (a_cls >= C_SNAN) || (b_use >= C_SNAN);
  assign qnan_any = (a_cls == C_QNAN) || (b_use == C_QNAN);
  assign eff_sub  = (op == OP_ADD) ? (a_sign != b_sign) : (a_sign == b_sign);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: indet = a_inf && b_inf && eff_sub;
      OP_MUL:         indet = (a_zero && b_inf) || (a_inf && b_zero);
      OP_DIV:         indet = (a_zero && b_zero) || (a_inf && b_inf);
      default:        indet = 1'b0;
    endcase
  end

  assign ev_inv   = stk_err || bad_cls || indet;
  assign ev_zd    = !ev_inv && (op == OP_DIV) && b_zero && a_fin_nz;
  assign ev_den   = !ev_inv && ((a_cls == C_DEN) || (b_use == C_DEN));
  assign arith_ok = !ev_inv && !ev_zd && !qnan_any && !(ev_den && !mask_bits[B_DEN]);

  assign ev[B_INV] = ev_inv;
  assign ev[B_DEN] = ev_den;
  assign ev[B_ZD]  = ev_zd;
  assign ev[B_OVF] = arith_ok && rnd_ovf;
  assign ev[B_UNF] = arith_ok && rnd_unf && (!mask_bits[B_UNF] || rnd_inx);
  assign ev[B_PRC] = arith_ok && rnd_inx;

  always_comb begin
    case (rnd_mode)
      2'd0:    ovf_to_inf = 1'b1;
      2'd1:    ovf_to_inf = res_sign;
      2'd2:    ovf_to_inf = !res_sign;
      default: ovf_to_inf = 1'b0;
    endcase
  end

  always_comb begin
    sel_d = S_PASS;
    if (ev_inv) begin
      if (!mask_bits[B_INV])   sel_d = S_HOLD;
      else if (dest_fmt == 2'd1) sel_d = S_IIND;
      else if (dest_fmt == 2'd2) sel_d = S_BIND;
      else                       sel_d = S_QNAN;
    end else if (ev_zd) begin
      sel_d = mask_bits[B_ZD] ? S_INF : S_HOLD;
    end else if (ev_den && !mask_bits[B_DEN]) begin
      sel_d = S_HOLD;
    end else if (ev[B_OVF]) begin
      if (!mask_bits[B_OVF]) sel_d = S_HOLD;
      else                   sel_d = ovf_to_inf ? S_INF : S_MAXF;
    end else if (ev[B_UNF]) begin
      sel_d = mask_bits[B_UNF] ? S_DENZ : S_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags       <= '0;
      stack_fault <= 1'b0;
      repl_sel    <= S_PASS;
      out_valid   <= 1'b0;
    end else begin
      flags       <= (clr_flags ? '0 : flags) | (in_valid ? ev : '0);
      stack_fault <= (!clr_flags && stack_fault) || (in_valid && stk_err);
      repl_sel    <= in_valid ? sel_d : S_PASS;
      out_valid   <= in_valid;
    end
  end

  assign err_summary = |(flags & ~mask_bits);
endmodule

module fp_exc_resolve_chk #(
  parameter int NFLAG = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             clr_flags,
  input logic [NFLAG-1:0] flags,
  input logic             stack_fault,
  input logic             err_summary,
  input logic [2:0]       repl_sel,
  input logic             out_valid
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && repl_sel == 3'd0));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> ((flags & $past(flags)) == $past(flags)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr_flags) |=> ($stable(flags) && $stable(stack_fault)));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !in_valid) |=> (flags == '0 && !stack_fault));
  a_r2_fault_is_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> flags[0]);
  a_r3_nan_needs_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && repl_sel >= 3'd1 && repl_sel <= 3'd3) |-> flags[0]);
  a_r11_no_flag_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !err_summary);
endmodule

bind fp_exc_resolve fp_exc_resolve_chk #(.NFLAG(NFLAG)) u_chk (.*);

// File: tb/sim_fp_exc_resolve.sv
module sim_fp_exc_resolve;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [2:0] op = 0, a_cls = 0, b_cls = 0;
  logic a_sign = 0, b_sign = 0, res_sign = 0;
  logic [1:0] rnd_mode = 0, dest_fmt = 0;
  logic rnd_ovf = 0, rnd_unf = 0, rnd_inx = 0, stk_err = 0, clr_flags = 0;
  logic [5:0] mask_bits = 6'h3F;
  logic [5:0] flags;
  logic stack_fault, err_summary, out_valid;
  logic [2:0] repl_sel;

  always #10 clk = ~clk;

  fp_exc_resolve u0 (.*);

  typedef struct {
    string tag; logic [2:0] sel; logic [5:0] fl; logic sf; logic err;
  } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0;
  logic [5:0] exp_fl = 0;
  logic exp_sf = 0;

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // independent model of the requirements
  task automatic model(input logic [2:0] o, a, b, input logic as_, bs, rs,
                       input logic [1:0] rm, input logic ov, un, ix, sk,
                       input logic [5:0] m, input logic [1:0] fmt,
                       output logic [5:0] ev, output logic [2:0] sel);
    logic [2:0] bb;
    logic inv, zd, den, qn, go, toinf;
    bb = (o >= 3'd4) ? 3'd0 : b;
    inv = sk || a == 5 || a == 6 || a == 7 || bb == 5 || bb == 6 || bb == 7;
    if (o == 2 && ((a == 1 && bb == 3) || (a == 3 && bb == 1))) inv = 1;
    if (o == 3 && ((a == 1 && bb == 1) || (a == 3 && bb == 3))) inv = 1;
    if (o == 0 && a == 3 && bb == 3 && as_ != bs) inv = 1;
    if (o == 1 && a == 3 && bb == 3 && as_ == bs) inv = 1;
    zd  = !inv && o == 3 && bb == 1 && (a == 0 || a == 2);
    den = !inv && (a == 2 || bb == 2);
    qn  = a == 4 || bb == 4;
    go  = !inv && !zd && !qn && !(den && !m[1]);
    ev = {go && ix, go && un && (!m[4] || ix), go && ov, zd, den, inv};
    toinf = (rm == 0) || (rm == 1 && rs) || (rm == 2 && !rs);
    sel = 0;
    if (inv) sel = !m[0] ? 7 : (fmt == 1 ? 2 : (fmt == 2 ? 3 : 1));
    else if (zd) sel = m[2] ? 4 : 7;
    else if (den && !m[1]) sel = 7;
    else if (ev[3]) sel = !m[3] ? 7 : (toinf ? 4 : 5);
    else if (ev[4]) sel = m[4] ? 6 : 7;
  endtask

  task automatic run_op(string tag, logic [2:0] o, a, b, logic as_, bs, rs, logic [1:0] rm,
                        logic ov, un, ix, sk, logic [5:0] m, logic [1:0] fmt, logic clr);
    item_t it;
    logic [5:0] ev;
    logic [2:0] sel;
    @(negedge clk);
    model(o, a, b, as_, bs, rs, rm, ov, un, ix, sk, m, fmt, ev, sel);
    if (clr) begin exp_fl = 0; exp_sf = 0; end
    exp_fl |= ev;
    exp_sf |= sk;
    it.tag = tag; it.sel = sel; it.fl = exp_fl; it.sf = exp_sf;
    it.err = |(exp_fl & ~m);
    sbq.push_back(it);
    op = o; a_cls = a; b_cls = b; a_sign = as_; b_sign = bs; res_sign = rs;
    rnd_mode = rm; rnd_ovf = ov; rnd_unf = un; rnd_inx = ix; stk_err = sk;
    mask_bits = m; dest_fmt = fmt; clr_flags = clr; in_valid = 1;
    @(negedge clk);
    in_valid = 0; clr_flags = 0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    clr_flags = 1; exp_fl = 0; exp_sf = 0;
    @(negedge clk);
    clr_flags = 0;
    chk("R10", "flags after clear", flags, 0);
    chk("R10", "stack_fault after clear", stack_fault, 0);
  endtask

  always begin
    @(posedge clk); #5;
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) chk("R1", "unexpected out_valid", 1, 0);
      else begin
        item_t e;
        e = sbq.pop_front();
        chk(e.tag, "repl_sel", repl_sel, e.sel);
        chk(e.tag, "flags", flags, e.fl);
        chk(e.tag, "stack_fault", stack_fault, e.sf);
        chk(e.tag, "err_summary", err_summary, e.err);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset out_valid", out_valid, 0);
    chk("R10", "reset flags", flags, 0);
    chk("R1", "reset repl_sel", repl_sel, 0);
    chk("R11", "reset err_summary", err_summary, 0);

    run_op("R1 plain add",          0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R8 inexact masked",     0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6'h3F, 0, 0);
    run_op("R8 inexact unmasked",   2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6'h1F, 0, 0);
    clear_only();
    run_op("R3 snan real",          0, 5, 0, 0, 0, 0, 0, 1, 1, 1, 0, 6'h3F, 0, 0);
    run_op("R3 unsup integer",      2, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 1, 0);
    run_op("R3 class7 bcd",         1, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 2, 0);
    run_op("R3 fmt3 real",          3, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 3, 0);
    run_op("R3 invalid unmasked",   0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3E, 0, 0);
    clear_only();
    run_op("R2 stack error",        0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'h3F, 0, 0);
    clear_only();
    run_op("R9 R2 zero times inf",  2, 1, 3, 0, 0, 0, 0, 1, 1, 1, 0, 6'h3F, 0, 0);
    clear_only();
    run_op("R2 inf plus inf same",  0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R2 inf plus -inf",      0, 3, 3, 0, 1, 0, 0, 0, 0, 0, 0, 6'h3F, 1, 0);
    clear_only();
    run_op("R2 inf minus inf",      1, 3, 3, 1, 1, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R2 inf over inf",       3, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 2, 0);
    clear_only();
    run_op("R4 norm over zero",     3, 0, 1, 0, 0, 1, 0, 1, 0, 1, 0, 6'h3F, 0, 0);
    clear_only();
    run_op("R4 zero over zero",     3, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    clear_only();
    run_op("R4 inf over zero",      3, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R4 R5 den over zero",   3, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R4 zd unmasked",        3, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3B, 0, 0);
    clear_only();
    run_op("R5 den masked",         0, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 6'h3F, 0, 0);
    clear_only();
    run_op("R5 den unmasked",       2, 2, 0, 0, 0, 0, 0, 1, 1, 1, 0, 6'h3D, 0, 0);
    clear_only();
    for (int rm = 0; rm < 4; rm++)
      for (int s = 0; s < 2; s++)
        run_op("R6 masked overflow", 0, 0, 0, 0, 0, s[0], rm[1:0], 1, 0, 1, 0, 6'h3F, 0, 0);
    run_op("R6 overflow unmasked",  2, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 6'h37, 0, 0);
    clear_only();
    run_op("R7 underflow exact masked", 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 6'h3F, 0, 0);
    run_op("R7 underflow inexact masked", 3, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 6'h3F, 0, 0);
    clear_only();
    run_op("R7 underflow unmasked", 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 6'h2F, 0, 0);
    run_op("R11 masked again",      0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    clear_only();
    run_op("R9 qnan operand",       0, 4, 0, 0, 0, 0, 0, 1, 1, 1, 0, 6'h3F, 0, 0);
    run_op("R12 single op ignores B", 4, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R12 single op denormal", 5, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, 0);
    run_op("R10 clear with op",     0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6'h3F, 0, 1);

    repeat (3) @(negedge clk);
    chk("R1", "scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule